// File: doc/BRIEF.md
# Serial SAR ADC host controller

This block sits on the host side of a serial-output successive-approximation converter and produces every control line the converter needs from a single system clock. A start request runs one conversion. The block holds the converter's sample line high for the acquisition window, drops it with the converter clock parked low, and waits a setup gap. It then bursts exactly seventeen converter clocks and shifts in the sixteen-bit two's-complement result from the data line on the converter's data-clock edges. The word is presented with a one-cycle valid strobe and a flag that marks words from throw-away conversions.

The converter clock comes from a parameterised divider of the system clock. The default of 24 system cycles per half period gives about 480 ns at 100 MHz. After reset, and whenever the host asks for it, the block runs the calibration handshake and then one discarded conversion. The block also counts the system cycles since the last sample edge. When that gap has grown too long, it runs a refresh conversion before it delivers the next real result. Requests that arrive while the block is busy are remembered and served as soon as the current operation ends. A start that is pending when a burst ends raises the sample line again during the high half of the last clock.

Top module: `sar_adc_host`

## Requirements
- R1: While reset is held, the sample, converter-clock and calibrate outputs are low and valid_o is low.
- R2: After reset, and after each calibrate request, the block drives the calibrate line and the sample line high together. It keeps the converter clock running. It releases the calibrate line on the falling clock edge that ends at least CAL_HOLD (default 4) full clock periods. It keeps the sample line high and the clock running until BUSY is low, and it stops with the clock low.
- R3: The sample line stays high for at least ACQ_CYC system cycles. The converter clock is low when the sample line falls and is low in the cycle before. The first converter clock rise after the sample edge comes at least SETUP_CYC system cycles later.
- R4: Each conversion issues exactly 17 converter clock rising edges between the falling edge of the sample line and its next rise. Every low phase of the converter clock lasts at least HALF_DIV system cycles.
- R5: The result is the data-line level taken at data-clock rising edges 2 through 17, with the first taken bit as bit 15, the most significant bit. It appears on data_o together with a valid_o pulse that lasts exactly one cycle.
- R6: Every calibration is followed by one conversion whose word is flagged with dummy_o = 1. Only after that conversion does any pending start get served.
- R7: If the number of system cycles since the last falling edge of the sample line has reached STALE_CYC when a start is served, a conversion flagged dummy_o = 1 runs first. The start stays pending and then produces a word with dummy_o = 0.
- R8: A start that arrives during a calibration or a conversion is held and served afterwards. Several starts that arrive during one operation produce only one conversion.
- R9: When a start is pending at the 17th converter clock rise, the sample line rises in the same cycle as that clock edge, while the clock is still high.
- R10: A calibrate request that arrives during a conversion lets that conversion finish and deliver its word. The calibration and its dummy conversion follow, and no other conversion runs unless a start is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one conversion (pulse) |
| cal_i | input | 1 | Request a calibration (pulse) |
| adc_busy_i | input | 1 | Converter busy indication |
| adc_dout_i | input | 1 | Converter serial data |
| adc_doutclk_i | input | 1 | Converter data clock, bits taken on its rising edge |
| adc_sample_o | output | 1 | Converter sample line, high while acquiring |
| adc_clk_o | output | 1 | Converter clock |
| adc_cal_o | output | 1 | Converter calibrate line |
| data_o | output | 16 | Last captured two's-complement word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| dummy_o | output | 1 | The word came from a calibration-follow or refresh conversion |

## Verification
The assertions take for granted that HALF_DIV is at least two. They also assume that the converter's data clock is derived from the converter clock in step with the system clock, so that rising edges can be detected from one system cycle to the next, and that BUSY eventually falls during calibration. The bench stays within these limits. Its converter model changes its data line only on falling edges of the converter clock and forms the data clock by gating that clock. It lowers BUSY a fixed number of clocks after the calibrate line is released, and it issues start and calibrate requests as single-cycle pulses on the falling system-clock edge.

// File: rtl/sar_adc_host.sv
module sar_adc_host #(
  parameter int WORD_W    = 16,
  parameter int HALF_DIV  = 24,
  parameter int ACQ_CYC   = 200,
  parameter int SETUP_CYC = 5,
  parameter int CAL_HOLD  = 4,
  parameter int STALE_CYC = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cal_i,
  input  logic              adc_busy_i,
  input  logic              adc_dout_i,
  input  logic              adc_doutclk_i,
  output logic              adc_sample_o,
  output logic              adc_clk_o,
  output logic              adc_cal_o,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              dummy_o
);
  localparam int NCLK = WORD_W + 1;
  localparam int TMAX = (ACQ_CYC > SETUP_CYC) ? ACQ_CYC : SETUP_CYC;
  localparam int EMAX = (NCLK > CAL_HOLD) ? NCLK : CAL_HOLD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int DVW  = $clog2(HALF_DIV + 1);
  localparam int EW   = $clog2(EMAX + 1);
  localparam int IW   = $clog2(STALE_CYC + 1);
  localparam int BW   = $clog2(NCLK);

  typedef enum logic [2:0] {S_IDLE, S_CALH, S_CALR, S_ACQ, S_SET, S_BURST} st_t;

  st_t             st;
  logic [TW-1:0]   tcnt;
  logic [DVW-1:0]  dv;
  logic [EW-1:0]   ecnt;
  logic [IW-1:0]   icnt;
  logic [BW-1:0]   bcnt;
  logic [WORD_W-1:0] shreg;
  logic            cal_pend, start_pend, post_cal, nxt_dummy, conv_dummy, cap_on, dclk_q;

  wire clk_en   = (st == S_CALH) || (st == S_CALR) || (st == S_BURST) || adc_clk_o;
  wire tick     = clk_en && (dv == DVW'(HALF_DIV - 1));
  wire rise     = tick && !adc_clk_o;
  wire fall     = tick && adc_clk_o;
  wire stale    = (icnt == IW'(STALE_CYC));
  wire acq_end  = (st == S_ACQ) && (tcnt == TW'(ACQ_CYC - 1)) && !adc_clk_o;
  wire dclk_rise = adc_doutclk_i && !dclk_q;

  assign data_o = shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dv <= '0;
      adc_clk_o <= 1'b0;
    end else if (!clk_en) begin
      dv <= '0;
    end else if (tick) begin
      dv <= '0;
      adc_clk_o <= ~adc_clk_o;
    end else begin
      dv <= dv + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      tcnt <= '0;
      ecnt <= '0;
      icnt <= IW'(STALE_CYC);
      cal_pend <= 1'b1;
      start_pend <= 1'b0;
      post_cal <= 1'b0;
      nxt_dummy <= 1'b0;
      adc_sample_o <= 1'b0;
      adc_cal_o <= 1'b0;
    end else begin
      if (start_i) start_pend <= 1'b1;
      if (cal_i) cal_pend <= 1'b1;
      if (acq_end) icnt <= '0;
      else if (!stale) icnt <= icnt + 1'b1;
      case (st)
        S_IDLE: begin
          if (cal_pend) begin
            st <= S_CALH;
            adc_cal_o <= 1'b1;
            adc_sample_o <= 1'b1;
            cal_pend <= cal_i;
            ecnt <= '0;
          end else if (post_cal || start_pend) begin
            st <= S_ACQ;
            adc_sample_o <= 1'b1;
            tcnt <= '0;
            post_cal <= 1'b0;
            nxt_dummy <= post_cal || stale;
            if (!post_cal && !stale) start_pend <= start_i;
          end
        end
        S_CALH: begin
          if (rise) ecnt <= ecnt + 1'b1;
          if (fall && ecnt == EW'(CAL_HOLD)) begin
            adc_cal_o <= 1'b0;
            st <= S_CALR;
          end
        end
        S_CALR: begin
          if (!adc_busy_i && !adc_clk_o) begin
            st <= S_IDLE;
            post_cal <= 1'b1;
          end
        end
        S_ACQ: begin
          if (tcnt != TW'(ACQ_CYC - 1)) tcnt <= tcnt + 1'b1;
          if (acq_end) begin
            adc_sample_o <= 1'b0;
            st <= S_SET;
            tcnt <= '0;
          end
        end
        S_SET: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(SETUP_CYC - 1)) begin
            st <= S_BURST;
            ecnt <= '0;
          end
        end
        S_BURST: begin
          if (rise) begin
            ecnt <= ecnt + 1'b1;
            if (ecnt == EW'(NCLK - 1)) begin
              if (!cal_pend && start_pend) begin
                st <= S_ACQ;
                adc_sample_o <= 1'b1;
                tcnt <= '0;
                nxt_dummy <= stale;
                if (!stale) start_pend <= start_i;
              end else begin
                st <= S_IDLE;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dclk_q <= 1'b0;
      cap_on <= 1'b0;
      bcnt <= '0;
      shreg <= '0;
      valid_o <= 1'b0;
      conv_dummy <= 1'b0;
      dummy_o <= 1'b0;
    end else begin
      dclk_q <= adc_doutclk_i;
      valid_o <= 1'b0;
      if (acq_end) begin
        cap_on <= 1'b1;
        bcnt <= '0;
        conv_dummy <= nxt_dummy;
      end else if (cap_on && dclk_rise) begin
        bcnt <= bcnt + 1'b1;
        if (bcnt != '0) shreg <= {shreg[WORD_W-2:0], adc_dout_i};
        if (bcnt == BW'(NCLK - 1)) begin
          cap_on <= 1'b0;
          valid_o <= 1'b1;
          dummy_o <= conv_dummy;
        end
      end
    end
  end

  AST_SAMPLE_EDGE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_sample_o) |-> (!adc_clk_o && !$past(adc_clk_o))); // R3
  AST_CAL_WITH_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cal_o |-> adc_sample_o); // R2
  AST_CAL_RELEASE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cal_o) |-> !adc_clk_o); // R2
  AST_CLK_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_clk_o) |=> !adc_clk_o); // R4
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R5
endmodule

// File: tb/sar_adc_host_test.sv
module sar_adc_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;
  localparam int ACQ = 20;
  localparam int SETUP = 3;
  localparam int HOLD = 4;
  localparam int STALE = 600;
  localparam int CAL_LEN = 30;
  localparam logic [15:0] VEC [8] = '{16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000,
                                       16'h0001, 16'hA5C3, 16'h5A3C, 16'h8001};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic cal_i = 1'b0;
  logic adc_busy_i, adc_dout_i, adc_doutclk_i;
  logic adc_sample_o, adc_clk_o, adc_cal_o, valid_o, dummy_o;
  logic [15:0] data_o;
  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sar_adc_host #(.WORD_W(16), .HALF_DIV(HALF), .ACQ_CYC(ACQ), .SETUP_CYC(SETUP),
                 .CAL_HOLD(HOLD), .STALE_CYC(STALE)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_i(cal_i),
    .adc_busy_i(adc_busy_i), .adc_dout_i(adc_dout_i), .adc_doutclk_i(adc_doutclk_i),
    .adc_sample_o(adc_sample_o), .adc_clk_o(adc_clk_o), .adc_cal_o(adc_cal_o),
    .data_o(data_o), .valid_o(valid_o), .dummy_o(dummy_o));

  logic [15:0] model_word = 16'h0;
  logic [15:0] m_word = 16'h0;
  logic m_busy = 1'b0;
  logic m_dout = 1'b0;
  logic m_act = 1'b0;
  logic m_incal = 1'b0;
  int m_k = 0;
  int m_cc = 0;
  assign adc_busy_i = m_busy;
  assign adc_dout_i = m_dout;
  assign adc_doutclk_i = adc_clk_o & (m_act | m_incal);

  always @(negedge adc_sample_o) begin
    if (!adc_cal_o && !m_incal) begin
      m_act <= 1'b1;
      m_k <= 0;
      m_word <= model_word;
    end
  end

  always @(posedge adc_clk_o) begin
    if (adc_cal_o) begin
      m_busy <= 1'b1;
      m_incal <= 1'b1;
      m_cc <= 0;
      m_act <= 1'b0;
    end else if (m_incal) begin
      m_cc <= m_cc + 1;
      if (m_cc == CAL_LEN - 1) begin
        m_busy <= 1'b0;
        m_incal <= 1'b0;
      end
    end else if (m_act) begin
      m_k <= m_k + 1;
      if (m_k == 0) m_busy <= 1'b1;
      if (m_k == 16) m_busy <= 1'b0;
    end
  end

  always @(negedge adc_clk_o) begin
    if (m_incal) m_dout <= 1'b0;
    else if (m_act) begin
      if (m_k >= 1 && m_k <= 16) m_dout <= m_word[16 - m_k];
      else if (m_k >= 17) begin
        m_act <= 1'b0;
        m_dout <= 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic p_clk, p_smp, p_cal, conv_on;
  int low_len, hi_len, rises, since_fall, cal_rises, cal_bad;
  always @(negedge clk) begin
    if (!rst_n) begin
      p_clk = 0; p_smp = 0; p_cal = 0; conv_on = 0;
      low_len = 0; hi_len = 0; rises = 0; since_fall = 0; cal_rises = 0; cal_bad = 0;
    end else begin
      if (conv_on) since_fall++;
      if (adc_clk_o && !p_clk) begin
        chk(low_len >= HALF, "R4", "clock low phase", low_len, HALF);
        if (conv_on) begin
          if (rises == 0) chk(since_fall >= SETUP, "R3", "setup gap", since_fall, SETUP);
          rises++;
        end
        if (adc_cal_o) cal_rises++;
        low_len = 0;
      end else if (!adc_clk_o) low_len++;
      if (adc_cal_o && !adc_sample_o) cal_bad++;
      if (!adc_sample_o && p_smp) begin
        chk(hi_len >= ACQ, "R3", "acquisition length", hi_len, ACQ);
        chk(!adc_clk_o, "R3", "clock at sample edge", adc_clk_o, 0);
        conv_on = 1; rises = 0; since_fall = 0;
      end
      if (adc_sample_o && !p_smp && conv_on) begin
        chk(rises == 17, "R4", "clocks per conversion", rises, 17);
        conv_on = 0;
      end
      if (adc_sample_o) hi_len++; else hi_len = 0;
      if (!adc_cal_o && p_cal) begin
        chk(cal_rises >= HOLD, "R2", "calibrate hold clocks", cal_rises, HOLD);
        chk(cal_bad == 0, "R2", "sample low during calibrate", cal_bad, 0);
        cal_rises = 0; cal_bad = 0;
      end
      p_clk = adc_clk_o; p_smp = adc_sample_o; p_cal = adc_cal_o;
    end
  end

  task automatic wait_valid(output logic [15:0] d, output logic dm);
    do @(negedge clk); while (!valid_o);
    d = data_o;
    dm = dummy_o;
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_busy();
    do @(negedge clk); while (!adc_busy_i);
  endtask

  task automatic count_valids(input int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (valid_o) c++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic dm;
    int c;
    bit cal_seen;
    repeat (3) @(negedge clk);
    chk(adc_sample_o == 1'b0, "R1", "sample in reset", adc_sample_o, 0);
    chk(adc_clk_o == 1'b0, "R1", "clock in reset", adc_clk_o, 0);
    chk(adc_cal_o == 1'b0, "R1", "calibrate in reset", adc_cal_o, 0);
    chk(valid_o == 1'b0, "R1", "valid in reset", valid_o, 0);
    rst_n = 1'b1;
    model_word = VEC[0];
    repeat (3) @(negedge clk);
    chk(adc_cal_o == 1'b1, "R2", "power-up calibrate", adc_cal_o, 1);
    pulse_start();
    wait_valid(d, dm);
    chk(dm == 1'b1, "R6", "post-calibration dummy", dm, 1);
    wait_valid(d, dm);
    chk(dm == 1'b0, "R8", "start held over calibration", dm, 0);
    chk(d == VEC[0], "R5", "word 0", d, VEC[0]);

    for (int i = 1; i < 8; i++) begin
      model_word = VEC[i];
      pulse_start();
      wait_valid(d, dm);
      chk(dm == 1'b0, "R5", "vector flag", dm, 0);
      chk(d == VEC[i], "R5", "vector word", d, VEC[i]);
    end

    model_word = 16'h1234;
    pulse_start();
    wait_busy();
    model_word = 16'hC0DE;
    pulse_start();
    @(negedge clk);
    pulse_start();
    do @(negedge clk); while (!adc_sample_o);
    chk(adc_clk_o == 1'b1, "R9", "sample raised in last clock high", adc_clk_o, 1);
    wait_valid(d, dm);
    chk(d == 16'h1234 && !dm, "R8", "word before held start", d, 16'h1234);
    wait_valid(d, dm);
    chk(d == 16'hC0DE && !dm, "R9", "back-to-back word", d, 16'hC0DE);
    count_valids(300, c);
    chk(c == 0, "R8", "merged starts give one conversion", c, 0);

    repeat (700) @(negedge clk);
    model_word = 16'h4321;
    pulse_start();
    wait_valid(d, dm);
    chk(dm == 1'b1, "R7", "refresh conversion flagged", dm, 1);
    wait_valid(d, dm);
    chk(dm == 1'b0 && d == 16'h4321, "R7", "word after refresh", d, 16'h4321);

    model_word = 16'h0F0F;
    pulse_start();
    wait_busy();
    cal_i = 1'b1;
    @(negedge clk);
    cal_i = 1'b0;
    wait_valid(d, dm);
    chk(dm == 1'b0 && d == 16'h0F0F, "R10", "conversion finishes before calibrate", d, 16'h0F0F);
    cal_seen = 0;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (adc_cal_o) cal_seen = 1;
    end
    chk(cal_seen, "R10", "calibrate follows", cal_seen, 1);
    wait_valid(d, dm);
    chk(dm == 1'b1, "R6", "dummy after requested calibrate", dm, 1);
    count_valids(250, c);
    chk(c == 0, "R10", "no extra conversion", c, 0);
    model_word = 16'h7001;
    pulse_start();
    wait_valid(d, dm);
    chk(dm == 1'b0 && d == 16'h7001, "R10", "start after calibrate", d, 16'h7001);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule